// File: doc/BRIEF.md
# Coprocessor Permission and Access Gate

This block holds two small system control registers that together decide whether an instruction may use any of fourteen coprocessors. One is a secure-owned permission register with a single grant bit per coprocessor. It says which coprocessors the non-secure world may touch at all. The other is an access register with a two-bit rights field per coprocessor. Coprocessor n owns bits 2n+1:2n of that register, so coprocessor 10 sits in bits 21:20 and coprocessor 11 in bits 23:22.

Software reaches the registers through a register port. Each request on that port carries the current security state and privilege level, and the block enforces who may read or write each register. When non-secure code writes the access register, only the fields that the permission register grants take the new value. A separate combinational check port gives the decode stage a single deny answer for a coprocessor number, security state and privilege level. For a non-secure request, the permission bit vetoes the access before the rights field is looked at. A parameter removes security-extension support. With it removed, the permission register reads as zero and plays no part.

Top module: `cp_gate`

## Requirements
- R1: The permission register keeps bits 13:0 of a write, one bit per coprocessor 0..13. Bits 31:14 always read as zero.
- R2: After reset, both registers read as zero, and every coprocessor check is denied.
- R3: Only a secure request at privilege level 3 may write the permission register. A read is allowed at secure level 3 and at level 1 in either state. Any other request raises reg_err, returns zero read data and leaves the register unchanged.
- R4: A write to the access register is first ANDed with the mask of implemented fields. This mask covers the fields of the coprocessors set in CP_IMPL, plus bits 23:20 when FP_PRESENT is set. All other bits always read as zero.
- R5: A non-secure write to the access register, with security extensions present, updates field n (bits 2n+1:2n) only when permission bit n is set. Every other field keeps its value.
- R6: A secure write to the access register is not filtered by the permission register.
- R7: The access register may be read or written at privilege levels 1 to 3 in either state. At level 0, reg_err is raised and the register is unchanged. reg_sel = 0 selects the access register and reg_sel = 1 selects the permission register.
- R8: A non-secure check of coprocessor n, with security extensions present, is denied whenever permission bit n is clear, whatever its rights field holds.
- R9: The rights field decides a check that passes R8:
  - 00 denies.
  - 01 allows privileged requests (level other than 0) only.
  - 11 allows every level.
  - 10 is reserved and denies.
  - Coprocessor numbers 14 and 15 are always denied.
- R10: With SEC_EXT = 0, the permission register reads as zero and cannot be written. Non-secure access-register writes are unfiltered, and non-secure checks are not vetoed.
- R11: The check port is combinational and sees register contents as they were before the current edge. A register write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_en | input | 1 | Register request valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 1 | 0 = access register, 1 = permission register |
| reg_sec | input | 1 | Requester is in secure state |
| reg_pl | input | 2 | Requester privilege level (0..3) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero unless a permitted read |
| reg_err | output | 1 | Request not permitted at this state and level |
| chk_cp | input | 4 | Coprocessor number to check |
| chk_sec | input | 1 | Checked instruction runs in secure state |
| chk_pl | input | 2 | Checked instruction privilege level |
| chk_deny | output | 1 | 1 = coprocessor use denied |

## Verification
A register write and a coprocessor check can land in the same cycle. The bench provokes this by driving a secure access-register write and a check of the field being rewritten together. The check is judged against the old field value. A plain check one cycle later must see the new value. A second instance built without security extensions gets every stimulus at the same time, so each write, read and check is also judged against the unfiltered behaviour.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  localparam int CP_COUNT = 14;
  localparam int CP_IDX_W = 4;
  localparam int REG_W    = 32;
  localparam int FP_LO_CP = 10;

  typedef enum logic [1:0] {
    FLD_NONE = 2'b00,
    FLD_PRIV = 2'b01,
    FLD_RSVD = 2'b10,
    FLD_FULL = 2'b11
  } cp_field_e;

  // each grant bit n widened into the two-bit field at 2n+1:2n
  function automatic logic [REG_W-1:0] spread_mask(input logic [CP_COUNT-1:0] bits);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < CP_COUNT; i++) begin
      r[2*i +: 2] = {2{bits[i]}};
    end
    return r;
  endfunction

  function automatic logic [1:0] field_of(input logic [REG_W-1:0] r,
                                          input logic [CP_IDX_W-1:0] n);
    return r[2*n +: 2];
  endfunction

  function automatic logic field_grants(input logic [1:0] f, input logic priv);
    case (cp_field_e'(f))
      FLD_FULL: return 1'b1;
      FLD_PRIV: return priv;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cpg_ctl_reg.sv
module cpg_ctl_reg #(
  parameter int W       = 32,
  parameter bit PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (PRESENT) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= d;
      end
    end else begin : g_absent
      assign q = '0;
    end
  endgenerate
endmodule

// File: rtl/cpg_acc_merge.sv
module cpg_acc_merge
  import cpg_pkg::*;
#(
  parameter bit SEC_EXT = 1'b1
) (
  input  logic [REG_W-1:0]    wdata,
  input  logic [REG_W-1:0]    impl_fields,
  input  logic [REG_W-1:0]    cur,
  input  logic [CP_COUNT-1:0] perm,
  input  logic                sec,
  output logic [REG_W-1:0]    take_mask,
  output logic [REG_W-1:0]    next
);
  logic filter_on;

  always_comb begin
    filter_on = SEC_EXT && !sec;
    take_mask = filter_on ? spread_mask(perm) : '1;
    next      = (wdata & impl_fields & take_mask) | (cur & ~take_mask);
  end
endmodule

// File: rtl/cpg_check.sv
module cpg_check
  import cpg_pkg::*;
#(
  parameter bit SEC_EXT = 1'b1
) (
  input  logic [CP_IDX_W-1:0] cp,
  input  logic                sec,
  input  logic [1:0]          pl,
  input  logic [CP_COUNT-1:0] perm,
  input  logic [REG_W-1:0]    acc,
  output logic                veto,
  output logic                deny
);
  logic                in_range;
  logic [CP_IDX_W-1:0] cp_safe;
  logic [1:0]          fld;

  always_comb begin
    in_range = (cp < CP_IDX_W'(CP_COUNT));
    cp_safe  = in_range ? cp : '0;
    fld      = field_of(acc, cp_safe);
    veto     = SEC_EXT && in_range && !sec && !perm[cp_safe];
    deny     = !in_range || veto || !field_grants(fld, pl != 2'd0);
  end
endmodule

// File: rtl/cp_gate.sv
module cp_gate
  import cpg_pkg::*;
#(
  parameter bit                SEC_EXT    = 1'b1,
  parameter bit                FP_PRESENT = 1'b1,
  parameter logic [CP_COUNT-1:0] CP_IMPL  = 14'h0003
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_en,
  input  logic                reg_wr,
  input  logic                reg_sel,
  input  logic                reg_sec,
  input  logic [1:0]          reg_pl,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                reg_err,
  input  logic [CP_IDX_W-1:0] chk_cp,
  input  logic                chk_sec,
  input  logic [1:0]          chk_pl,
  output logic                chk_deny
);
  localparam logic [CP_COUNT-1:0] FP_BITS     = CP_COUNT'(2'b11) << FP_LO_CP;
  localparam logic [CP_COUNT-1:0] IMPL_BITS   = CP_IMPL | (FP_PRESENT ? FP_BITS : '0);
  localparam logic [REG_W-1:0]    IMPL_FIELDS = spread_mask(IMPL_BITS);
  localparam logic [REG_W-1:0]    PERM_KEEP   = REG_W'({CP_COUNT{1'b1}});

  logic [REG_W-1:0] perm_q, acc_q, acc_next, take_mask;
  logic top_secure, permit_rd_ok, access_ok, sel_ok;
  logic perm_wr_fire, acc_wr_fire, ns_veto;

  // request qualification
  always_comb begin
    top_secure   = reg_sec && (reg_pl == 2'd3);
    permit_rd_ok = top_secure || (reg_pl == 2'd1);
    access_ok    = (reg_pl != 2'd0);
    if (reg_sel) sel_ok = reg_wr ? top_secure : permit_rd_ok;
    else         sel_ok = access_ok;
    reg_err      = reg_en && !sel_ok;
    perm_wr_fire = reg_en && reg_wr &&  reg_sel && top_secure;
    acc_wr_fire  = reg_en && reg_wr && !reg_sel && access_ok;
    if (reg_en && !reg_wr && sel_ok) reg_rdata = reg_sel ? perm_q : acc_q;
    else                             reg_rdata = '0;
  end

  cpg_ctl_reg #(.W(REG_W), .PRESENT(SEC_EXT)) u_perm (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (perm_wr_fire),
    .d     (reg_wdata & PERM_KEEP),
    .q     (perm_q)
  );

  cpg_acc_merge #(.SEC_EXT(SEC_EXT)) u_merge (
    .wdata       (reg_wdata),
    .impl_fields (IMPL_FIELDS),
    .cur         (acc_q),
    .perm        (perm_q[CP_COUNT-1:0]),
    .sec         (reg_sec),
    .take_mask   (take_mask),
    .next        (acc_next)
  );

  cpg_ctl_reg #(.W(REG_W), .PRESENT(1'b1)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (acc_wr_fire),
    .d     (acc_next),
    .q     (acc_q)
  );

  cpg_check #(.SEC_EXT(SEC_EXT)) u_check (
    .cp   (chk_cp),
    .sec  (chk_sec),
    .pl   (chk_pl),
    .perm (perm_q[CP_COUNT-1:0]),
    .acc  (acc_q),
    .veto (ns_veto),
    .deny (chk_deny)
  );
endmodule

// File: rtl/cp_gate_chk.sv
module cp_gate_chk
  import cpg_pkg::*;
#(
  parameter bit SEC_EXT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_en,
  input logic                reg_wr,
  input logic                reg_sel,
  input logic                reg_sec,
  input logic [1:0]          reg_pl,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [CP_IDX_W-1:0] chk_cp,
  input logic                chk_sec,
  input logic                chk_deny,
  input logic [REG_W-1:0]    perm_q,
  input logic [REG_W-1:0]    acc_q,
  input logic                acc_wr_fire,
  input logic [REG_W-1:0]    impl_fields
);
  // R3: permission register moves only after a secure level-3 write
  p_perm_write_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(perm_q) |-> $past(reg_en && reg_wr && reg_sel && reg_sec && reg_pl == 2'd3));

  // R4: no unimplemented field ever holds a one
  p_impl_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q & ~impl_fields) == '0);

  // R5: non-secure write leaves fields without a grant untouched
  p_ns_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_fire && SEC_EXT && !reg_sec) |=>
      ((acc_q ^ $past(acc_q)) & ~spread_mask($past(perm_q[CP_COUNT-1:0]))) == '0);

  // R6: secure write lands unfiltered apart from the implemented mask
  p_secure_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_fire && reg_sec) |=> acc_q == ($past(reg_wdata) & impl_fields));

  // R8: missing grant bit forces a deny for non-secure use
  p_ns_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (SEC_EXT && !chk_sec && chk_cp < CP_IDX_W'(CP_COUNT) && !perm_q[chk_cp]) |-> chk_deny);

  // R9: reserved encoding and out-of-range numbers deny
  p_rsvd_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_cp >= CP_IDX_W'(CP_COUNT) || field_of(acc_q, chk_cp) == 2'b10) |-> chk_deny);
endmodule

bind cp_gate cp_gate_chk #(.SEC_EXT(SEC_EXT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_en      (reg_en),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_sec     (reg_sec),
  .reg_pl      (reg_pl),
  .reg_wdata   (reg_wdata),
  .chk_cp      (chk_cp),
  .chk_sec     (chk_sec),
  .chk_deny    (chk_deny),
  .perm_q      (perm_q),
  .acc_q       (acc_q),
  .acc_wr_fire (acc_wr_fire),
  .impl_fields (IMPL_FIELDS)
);

// File: tb/test_cp_gate.sv
module test_cp_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [13:0] T_IMPL = 14'h0003;
  localparam logic [13:0] T_CPS  = T_IMPL | 14'h0C00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_en = 0, reg_wr = 0, reg_sel = 0, reg_sec = 0;
  logic [1:0] reg_pl = 0;
  logic [31:0] reg_wdata = 0;
  logic [3:0] chk_cp = 0;
  logic chk_sec = 0;
  logic [1:0] chk_pl = 0;
  logic [31:0] rd_a, rd_b;
  logic err_a, err_b, deny_a, deny_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_gate #(.SEC_EXT(1'b1), .FP_PRESENT(1'b1), .CP_IMPL(T_IMPL)) i_cp_gate (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_sec(reg_sec), .reg_pl(reg_pl), .reg_wdata(reg_wdata), .reg_rdata(rd_a),
    .reg_err(err_a), .chk_cp(chk_cp), .chk_sec(chk_sec), .chk_pl(chk_pl), .chk_deny(deny_a));

  cp_gate #(.SEC_EXT(1'b0), .FP_PRESENT(1'b1), .CP_IMPL(T_IMPL)) i_cp_gate_nosec (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_sec(reg_sec), .reg_pl(reg_pl), .reg_wdata(reg_wdata), .reg_rdata(rd_b),
    .reg_err(err_b), .chk_cp(chk_cp), .chk_sec(chk_sec), .chk_pl(chk_pl), .chk_deny(deny_b));

  typedef enum {K_READ, K_WERR, K_CHECK} kind_e;
  typedef struct {
    kind_e kind; int req;
    logic [31:0] rd_a, rd_b; logic err; logic deny_a, deny_b;
  } item_t;

  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [13:0] m_perm = '0;
  logic [31:0] m_acc_a = '0, m_acc_b = '0;

  // model: legality of a register request (R3, R7)
  function automatic bit m_err(bit sel, bit wr, bit sec, logic [1:0] pl);
    if (!sel) return pl == 2'd0;
    if (wr)   return !(sec && pl == 2'd3);
    return !((sec && pl == 2'd3) || pl == 2'd1);
  endfunction

  // model: field-by-field update of the access register (R4, R5, R6)
  function automatic logic [31:0] m_wr_acc(logic [31:0] acc, logic [13:0] perm,
                                           bit filter, logic [31:0] d);
    logic [31:0] r = acc;
    for (int c = 0; c < 14; c++)
      if (T_CPS[c] && (!filter || perm[c])) r[2*c +: 2] = d[2*c +: 2];
    return r;
  endfunction

  // model: decision for a coprocessor check (R8, R9)
  function automatic bit m_deny(logic [31:0] acc, logic [13:0] perm, bit secx,
                                int cp, bit sec, logic [1:0] pl);
    logic [1:0] f;
    if (cp > 13) return 1'b1;
    if (secx && !sec && !perm[cp]) return 1'b1;
    f = acc[2*cp +: 2];
    if (f == 2'b11) return 1'b0;
    if (f == 2'b01) return pl == 2'd0;
    return 1'b1;
  endfunction

  task automatic drive(bit en, bit wr, bit sel, bit sec, logic [1:0] pl, logic [31:0] d,
                       logic [3:0] cp, bit csec, logic [1:0] cpl);
    @(posedge clk); #1;
    reg_en = en; reg_wr = wr; reg_sel = sel; reg_sec = sec; reg_pl = pl; reg_wdata = d;
    chk_cp = cp; chk_sec = csec; chk_pl = cpl;
  endtask

  task automatic model_write(bit sel, bit sec, logic [1:0] pl, logic [31:0] d);
    if (m_err(sel, 1'b1, sec, pl)) return;
    if (sel) m_perm = d[13:0];
    else begin
      m_acc_a = m_wr_acc(m_acc_a, m_perm, !sec, d);
      m_acc_b = m_wr_acc(m_acc_b, 14'h0, 1'b0, d);
    end
  endtask

  task automatic do_write(int req, bit sel, bit sec, logic [1:0] pl, logic [31:0] d);
    item_t it;
    drive(1, 1, sel, sec, pl, d, 4'd0, 1'b1, 2'd3);
    it = '{K_WERR, req, 32'h0, 32'h0, m_err(sel, 1'b1, sec, pl), 1'b0, 1'b0};
    sb.push_back(it);
    model_write(sel, sec, pl, d);
  endtask

  task automatic do_read(int req, bit sel, bit sec, logic [1:0] pl);
    item_t it;
    bit e = m_err(sel, 1'b0, sec, pl);
    drive(1, 0, sel, sec, pl, 32'h0, 4'd0, 1'b1, 2'd3);
    it.kind = K_READ; it.req = req; it.err = e; it.deny_a = 0; it.deny_b = 0;
    it.rd_a = e ? 32'h0 : (sel ? {18'h0, m_perm} : m_acc_a);
    it.rd_b = e ? 32'h0 : (sel ? 32'h0 : m_acc_b);
    sb.push_back(it);
  endtask

  task automatic do_check(int req, int cp, bit sec, logic [1:0] pl);
    item_t it;
    drive(0, 0, 0, 0, 2'd0, 32'h0, 4'(cp), sec, pl);
    it = '{K_CHECK, req, 32'h0, 32'h0, 1'b0,
           m_deny(m_acc_a, m_perm, 1'b1, cp, sec, pl),
           m_deny(m_acc_b, 14'h0, 1'b0, cp, sec, pl)};
    sb.push_back(it);
  endtask

  // write and check in the same cycle: the check sees the old contents
  task automatic do_write_check(int req, bit sec, logic [1:0] pl, logic [31:0] d,
                                int cp, bit csec, logic [1:0] cpl);
    item_t it;
    drive(1, 1, 0, sec, pl, d, 4'(cp), csec, cpl);
    it = '{K_CHECK, req, 32'h0, 32'h0, 1'b0,
           m_deny(m_acc_a, m_perm, 1'b1, cp, csec, cpl),
           m_deny(m_acc_b, 14'h0, 1'b0, cp, csec, cpl)};
    sb.push_back(it);
    model_write(1'b0, sec, pl, d);
  endtask

  // monitor: pops one expected item per cycle, between edges
  initial begin
    forever begin
      item_t it;
      bit ok;
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_cmp++;
        case (it.kind)
          K_READ: begin
            ok = (err_a === it.err) && (err_b === it.err) &&
                 (rd_a === it.rd_a) && (rd_b === it.rd_b);
            if (!ok) $display("FAIL R%0d read: got rd %h/%h err %b/%b, exp rd %h/%h err %b",
                              it.req, rd_a, rd_b, err_a, err_b, it.rd_a, it.rd_b, it.err);
          end
          K_WERR: begin
            ok = (err_a === it.err) && (err_b === it.err);
            if (!ok) $display("FAIL R%0d write err: got %b/%b, exp %b",
                              it.req, err_a, err_b, it.err);
          end
          default: begin
            ok = (deny_a === it.deny_a) && (deny_b === it.deny_b);
            if (!ok) $display("FAIL R%0d check: got deny %b/%b, exp %b/%b",
                              it.req, deny_a, deny_b, it.deny_a, it.deny_b);
          end
        endcase
        if (!ok) n_bad++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout, exp finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: reset state
    do_read(2, 1'b1, 1'b1, 2'd3);
    do_read(2, 1'b0, 1'b1, 2'd1);
    do_check(2, 10, 1'b1, 2'd1);
    // R6 R4: secure write, only implemented fields kept (0x00F0000F)
    do_write(6, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    do_read(4, 1'b0, 1'b0, 2'd1);
    do_check(9, 11, 1'b1, 2'd0);
    // R3: who may touch the permission register
    do_read(3, 1'b1, 1'b0, 2'd1);
    do_write(3, 1'b1, 1'b0, 2'd1, 32'h3FFF);
    do_write(3, 1'b1, 1'b1, 2'd1, 32'h3FFF);
    do_write(3, 1'b1, 1'b0, 2'd3, 32'h3FFF);
    do_read(3, 1'b1, 1'b0, 2'd0);
    do_read(3, 1'b1, 1'b1, 2'd2);
    do_read(3, 1'b1, 1'b1, 2'd3);
    // R1: upper bits dropped, grants cp0, cp10, cp12, cp13
    do_write(1, 1'b1, 1'b1, 2'd3, 32'hFFFF_F401);
    do_read(1, 1'b1, 1'b1, 2'd3);
    do_read(10, 1'b1, 1'b0, 2'd1);
    // R5: non-secure write only reaches cp0 and cp10
    do_write(5, 1'b0, 1'b0, 2'd1, 32'h0);
    do_read(5, 1'b0, 1'b1, 2'd3);
    // R8: cp11 field is full yet non-secure use is vetoed
    do_check(8, 11, 1'b0, 2'd1);
    do_check(8, 11, 1'b1, 2'd0);
    do_check(10, 11, 1'b0, 2'd0);
    // R9: privileged-only encoding
    do_write(5, 1'b0, 1'b0, 2'd2, 32'h0010_0001);
    do_check(9, 10, 1'b0, 2'd0);
    do_check(9, 10, 1'b0, 2'd1);
    do_check(9, 0, 1'b0, 2'd3);
    // R9: reserved encoding, full encoding, out of range
    do_write(6, 1'b0, 1'b1, 2'd3, 32'h0020_0003);
    do_check(9, 10, 1'b1, 2'd1);
    do_check(9, 0, 1'b1, 2'd0);
    do_check(9, 14, 1'b1, 2'd3);
    do_check(9, 15, 1'b1, 2'd3);
    // R7: level 0 may not write the access register
    do_write(7, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    do_read(7, 1'b0, 1'b1, 2'd1);
    // R11: same-cycle write and check, then the new value
    do_write_check(11, 1'b1, 2'd1, 32'h00F0_0000, 0, 1'b1, 2'd0);
    do_check(11, 0, 1'b1, 2'd0);
    do_check(11, 11, 1'b1, 2'd0);
    // R10: non-secure write with no grants, filtered only when extensions exist
    do_write(1, 1'b1, 1'b1, 2'd3, 32'h0);
    do_write(10, 1'b0, 1'b0, 2'd1, 32'h0000_0005);
    do_read(10, 1'b0, 1'b0, 2'd1);
    do_check(10, 1, 1'b0, 2'd1);
    drive(0, 0, 0, 0, 2'd0, 32'h0, 4'd0, 1'b0, 2'd0);
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule